// File: doc/BRIEF.md
# Wear-Levelled Save Controller for Event Counter Storage

This block decides when a small set of working registers is written back to nonvolatile storage and which storage bank receives each write. Two register groups are tracked: the counter group (elapsed-time and event counters) and the shared group (configuration, alarm threshold and user bytes). A write into either group counts as a change only while the event input is high. When the event input falls, the block saves each changed group through a request/done handshake with a memory model.

Counter data is spread over three banks so that no bank wears out early. The bank is chosen from the event count that is present when the event ends. Bank 0 serves counts below one span, bank 1 serves counts from one span up to two spans, and bank 2 serves everything above that. One span is 50,000 by default. A counter cleared back to zero therefore writes to bank 0 again. The shared group always uses a fourth bank, and the block writes it only when that group has changed. After reset the block first issues a single restore request, which loads every working register from storage.

Top module: `nv_bank_ctrl`

## Requirements
- R1: After reset `mem_req` is high with `mem_restore`=1 and `mem_bank`=0. This restore is the only restore request until the next reset.
- R2: Once `mem_req` rises, it stays high, and `mem_bank` and `mem_restore` hold their values, until the cycle in which `mem_done` is sampled high.
- R3: A counter save uses `mem_bank` 0 when the count at the falling edge of `event_in` is below BANK_SPAN. It uses 1 for counts from BANK_SPAN to 2*BANK_SPAN-1, and 2 for counts of 2*BANK_SPAN and above.
- R4: After the event count returns to zero, the next counter save goes to bank 0, whatever bank was used before.
- R5: The shared group is saved with `mem_bank`=3, and only when `shr_touch` was high during the event that just ended.
- R6: When both groups changed, the counter save is requested first. The shared save is requested only after `mem_done` completes the counter save.
- R7: `ctr_touch` and `shr_touch` pulses while `event_in` is low mark nothing as changed.
- R8: An event that ends with no change in either group produces no save request.
- R9: An event that ends before the restore completes has its saves deferred until after the restore `mem_done`.
- R10: Change marks are consumed by the save, so a following event that has no changes issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| event_in | input | 1 | Event active level; its falling edge triggers saves |
| event_count | input | CNT_W | Current event count, used for bank choice |
| ctr_touch | input | 1 | Counter group written this cycle |
| shr_touch | input | 1 | Shared group written this cycle |
| mem_req | output | 1 | Storage request, held until done |
| mem_restore | output | 1 | 1: restore all registers, 0: save |
| mem_bank | output | 2 | Target bank: 0..2 counter banks, 3 shared bank |
| mem_done | input | 1 | Storage access finished |

## Verification
The assertions check four things on every cycle: the request stays stable until done, no restore occurs after boot, no save starts before the restore has finished, and a touch while the event is low never sets a change mark. The bench scenarios are needed to show the rest. They cover the bank chosen at each span boundary, the return to bank 0 after the count is cleared, the counter-then-shared order, the absence of any request for unchanged groups, and a save deferred behind the boot restore.

// File: rtl/nv_bank_ctrl.sv
module nv_bank_ctrl #(
  parameter int CNT_W     = 17,
  parameter int BANK_SPAN = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             event_in,
  input  logic [CNT_W-1:0] event_count,
  input  logic             ctr_touch,
  input  logic             shr_touch,
  output logic             mem_req,
  output logic             mem_restore,
  output logic [1:0]       mem_bank,
  input  logic             mem_done
);

  localparam logic [CNT_W-1:0] LIM1 = CNT_W'(BANK_SPAN);
  localparam logic [CNT_W-1:0] LIM2 = CNT_W'(2 * BANK_SPAN);
  localparam logic [1:0]       SHARED_BANK = 2'd3;

  typedef enum logic [1:0] {ST_LOAD, ST_IDLE, ST_CTR, ST_SHR} state_t;

  state_t     state;
  logic       ev_q, pend, booted;
  logic       ctr_dirty, shr_dirty, shr_sv;
  logic [1:0] bank_pend, bank_q, bank_sel;
  logic       fall, ctr_mark, shr_mark;

  assign fall     = ev_q & ~event_in;
  assign ctr_mark = ctr_touch & event_in;
  assign shr_mark = shr_touch & event_in;
  assign bank_sel = (event_count < LIM1) ? 2'd0 :
                    (event_count < LIM2) ? 2'd1 : 2'd2;

  assign mem_req     = (state != ST_IDLE);
  assign mem_restore = (state == ST_LOAD);
  assign mem_bank    = (state == ST_SHR) ? SHARED_BANK :
                       (state == ST_CTR) ? bank_q : 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_LOAD;
      ev_q      <= 1'b0;
      pend      <= 1'b0;
      booted    <= 1'b0;
      ctr_dirty <= 1'b0;
      shr_dirty <= 1'b0;
      shr_sv    <= 1'b0;
      bank_pend <= 2'd0;
      bank_q    <= 2'd0;
    end else begin
      ev_q <= event_in;
      if (ctr_mark) ctr_dirty <= 1'b1;
      if (shr_mark) shr_dirty <= 1'b1;
      case (state)
        ST_LOAD: if (mem_done) begin
          state  <= ST_IDLE;
          booted <= 1'b1;
        end
        ST_IDLE: if (pend) begin
          pend      <= 1'b0;
          bank_q    <= bank_pend;
          shr_sv    <= shr_dirty;
          ctr_dirty <= ctr_mark;
          shr_dirty <= shr_mark;
          state     <= ctr_dirty ? ST_CTR : (shr_dirty ? ST_SHR : ST_IDLE);
        end
        ST_CTR: if (mem_done) state <= shr_sv ? ST_SHR : ST_IDLE;
        ST_SHR: if (mem_done) begin
          state  <= ST_IDLE;
          shr_sv <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
      if (fall) begin
        pend      <= 1'b1;
        bank_pend <= bank_sel;
      end
    end
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_done |=> mem_req && $stable(mem_bank) && $stable(mem_restore));

  assert_single_restore_R1: assert property (@(posedge clk) disable iff (!rst_n)
    booted |-> !mem_restore);

  assert_save_after_boot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) && !mem_restore |-> booted);

  assert_ctr_idle_touch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !event_in && !ctr_dirty |=> !ctr_dirty);

  assert_shr_idle_touch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !event_in && !shr_dirty |=> !shr_dirty);

endmodule

// File: tb/nv_bank_ctrl_test.sv
module nv_bank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        event_in = 1'b0;
  logic [16:0] event_count = '0;
  logic        ctr_touch = 1'b0;
  logic        shr_touch = 1'b0;
  logic        mem_done = 1'b0;
  logic        mem_req, mem_restore;
  logic [1:0]  mem_bank;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  nv_bank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .event_in(event_in), .event_count(event_count),
    .ctr_touch(ctr_touch), .shr_touch(shr_touch), .mem_req(mem_req),
    .mem_restore(mem_restore), .mem_bank(mem_bank), .mem_done(mem_done)
  );

  // {count, ctr touch, shr touch, expected requests, first bank, second bank}
  localparam logic [24:0] VEC [8] = '{
    {17'd10,     1'b1, 1'b0, 2'd1, 2'd0, 2'd0},
    {17'd49999,  1'b1, 1'b1, 2'd2, 2'd0, 2'd3},
    {17'd50000,  1'b1, 1'b0, 2'd1, 2'd1, 2'd0},
    {17'd99999,  1'b1, 1'b1, 2'd2, 2'd1, 2'd3},
    {17'd100000, 1'b1, 1'b0, 2'd1, 2'd2, 2'd0},
    {17'd131071, 1'b0, 1'b1, 2'd1, 2'd3, 2'd0},
    {17'd0,      1'b1, 1'b1, 2'd2, 2'd0, 2'd3},
    {17'd77777,  1'b0, 1'b0, 2'd0, 2'd0, 2'd0}
  };

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_event(int cnt, bit ct, bit st);
    @(negedge clk) event_in = 1'b1;
    @(negedge clk) begin ctr_touch = ct; shr_touch = st; end
    @(negedge clk) begin ctr_touch = 1'b0; shr_touch = 1'b0; end
    @(negedge clk) begin event_in = 1'b0; event_count = 17'(cnt); end
  endtask

  task automatic collect(output int n, output int b0, output int b1,
                         output int r0, output int r1);
    n = 0; b0 = 0; b1 = 0; r0 = 0; r1 = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (mem_done) mem_done = 1'b0;
      else if (mem_req) begin
        int b, r;
        b = mem_bank; r = mem_restore;
        @(negedge clk);
        chk("R2 req held", mem_req, 1);
        chk("R2 bank held", mem_bank, b);
        if (n == 0) begin b0 = b; r0 = r; end
        else begin b1 = b; r1 = r; end
        n++;
        mem_done = 1'b1;
      end
    end
  endtask

  initial begin
    #400000;
    failures++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, b0, b1, r0, r1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset req", mem_req, 1);
    chk("R1 reset restore", mem_restore, 1);
    chk("R1 reset bank", mem_bank, 0);

    // R9: event ends while restore still pending
    run_event(5, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9 still restoring", mem_restore, 1);
    collect(n, b0, b1, r0, r1);
    chk("R9 request count", n, 2);
    chk("R9 restore first", r0, 1);
    chk("R9 deferred save is save", r1, 0);
    chk("R9 deferred bank", b1, 0);

    for (int v = 0; v < 8; v++) begin
      logic [24:0] e;
      e = VEC[v];
      run_event(int'(e[24:8]), e[7], e[6]);
      collect(n, b0, b1, r0, r1);
      chk($sformatf("R3 R5 R8 vec%0d count", v), n, int'(e[5:4]));
      if (n > 0) begin
        chk($sformatf("R3 R4 vec%0d first bank", v), b0, int'(e[3:2]));
        chk($sformatf("R1 vec%0d no restore", v), r0, 0);
      end
      if (n > 1) chk($sformatf("R6 vec%0d second bank", v), b1, int'(e[1:0]));
      if (v == 7) chk("R10 marks consumed", n, 0);
    end

    // R7: touches with event low, then an event with no touches
    @(negedge clk) begin ctr_touch = 1'b1; shr_touch = 1'b1; end
    @(negedge clk) begin ctr_touch = 1'b0; shr_touch = 1'b0; end
    run_event(20, 1'b0, 1'b0);
    collect(n, b0, b1, r0, r1);
    chk("R7 idle touch ignored", n, 0);
    chk("R1 req idle", mem_req, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule